// File: doc/BRIEF.md
# Four-Corner Sensor Readout Reorderer

An image sensor that is read out from its four corners at the same time delivers a single packet per frame in which the four readout streams are interleaved one pixel at a time. This block takes that packet as a valid/ready stream of 16-bit pixels. The first pixel of a frame carries a start-of-frame marker. The block works out which corner each pixel came from and where that corner's read head was at that moment. It then writes the pixel to its natural raster location in a frame buffer, which a later consumer reads in plain raster order.

Each corner covers one quadrant of the frame. The two left-hand corners scan their rows from left to right and the two right-hand corners scan from right to left. The two top corners step downward after each quadrant row and the two bottom corners step upward. Because all four corners advance in lockstep, a single shared position counter plus the 2-bit corner number is enough to compute every address. The write address comes from mirroring that position and not from a running write pointer. The block raises a one-cycle done flag on the write of the last pixel of a frame. It sets a sticky length-error flag when a packet is cut short or when pixels arrive that belong to no frame.

Top module: `ccd_corner_reorder`

## Requirements
- R1: After reset, wr_en, frame_done and len_err are 0, and in_ready is 1. The block never stalls the input.
- R2: Counting from the marked pixel as k = 0, pixel k comes from corner k mod 4 and is at quadrant position g = k div 4: column c = g mod (COLS/2), row r = g div (COLS/2). Corner 0 is top-left, at (r, c). Corner 1 is top-right, at (r, COLS-1-c). Corner 2 is bottom-left, at (ROWS-1-r, c). Corner 3 is bottom-right, at (ROWS-1-r, COLS-1-c).
- R3: wr_addr = row*COLS + col, with the row in the upper ROWS_LOG2 bits and the column in the lower COLS_LOG2 bits. Over one complete frame every address is written exactly once.
- R4: Every accepted pixel of a frame produces exactly one write in the cycle after it is accepted, and wr_data equals the pixel value. wr_en is 0 in all other cycles.
- R5: A beat with in_valid=1 and in_sop=1 is pixel 0 of a new frame. Its write goes to address 0, whatever the earlier state.
- R6: frame_done is a one-cycle pulse in the same cycle as the write of pixel ROWS*COLS-1.
- R7: A cycle with in_valid=0 has no effect, whatever in_sop and in_data carry.
- R8: A pixel accepted with in_sop=0 when no frame is in progress (a run-long packet, or data before any marker) is not written, and it sets len_err.
- R9: A marked pixel that arrives before the current frame has completed sets len_err and starts the new frame.
- R10: len_err stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input ready (always 1) |
| in_sop | input | 1 | Marks the first pixel of a frame packet |
| in_data | input | PIX_W | Pixel value |
| wr_en | output | 1 | Frame buffer write strobe |
| wr_addr | output | ROWS_LOG2+COLS_LOG2 | Raster address row*COLS+col |
| wr_data | output | PIX_W | Pixel value to write |
| frame_done | output | 1 | Pulse with the last pixel's write |
| len_err | output | 1 | Sticky packet length error |

## Verification
The bench runs an 8x8 frame and checks every corner's first and last pixel. A mirroring fault shows up as a write to the wrong quadrant edge. A row-step fault lands pixels in the wrong row, which the exactly-once coverage of every address exposes. It also checks the quadrant row boundary and the final pixel, where an off-by-one in the last-pixel decode would move the done pulse or end the frame early. Short packets, stray pixels after a finished frame, and sop pulses on idle cycles between beats are all applied. A design that ignored the marker mid-frame would keep writing at the old position. One that honoured sop without valid would restart and scramble the addresses of the gapped frame.

// File: rtl/ccd_reorder_pkg.sv
package ccd_reorder_pkg;

    localparam int PIXEL_BITS = 16;

    typedef enum logic [1:0] {
        CORNER_TL = 2'd0,
        CORNER_TR = 2'd1,
        CORNER_BL = 2'd2,
        CORNER_BR = 2'd3
    } corner_e;

    // Right-hand corners scan columns in descending order.
    function automatic logic scans_left(input corner_e c);
        return (c == CORNER_TR) || (c == CORNER_BR);
    endfunction

    // Bottom corners scan rows in descending order.
    function automatic logic scans_up(input corner_e c);
        return (c == CORNER_BL) || (c == CORNER_BR);
    endfunction

endpackage

// File: rtl/quad_seq.sv
module quad_seq #(
    parameter int QROW_W = 11,
    parameter int QCOL_W = 11
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         step,
    input  logic                         restart,
    output ccd_reorder_pkg::corner_e     corner,
    output logic [QROW_W-1:0]            qrow,
    output logic [QCOL_W-1:0]            qcol,
    output logic                         last_pix
);
    import ccd_reorder_pkg::*;

    corner_e             corner_q, corner_n;
    logic [QROW_W-1:0]   row_q, row_n;
    logic [QCOL_W-1:0]   col_q, col_n;

    // A marked beat is position zero regardless of the stored state.
    always_comb begin
        corner = restart ? CORNER_TL : corner_q;
        qrow   = restart ? '0 : row_q;
        qcol   = restart ? '0 : col_q;
    end

    assign last_pix = (corner == CORNER_BR) && (&qrow) && (&qcol);

    always_comb begin
        corner_n = corner_e'(corner + 2'd1);
        col_n    = qcol;
        row_n    = qrow;
        if (corner == CORNER_BR) begin
            col_n = qcol + 1'b1;
            if (&qcol) begin
                row_n = qrow + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            corner_q <= CORNER_TL;
            row_q    <= '0;
            col_q    <= '0;
        end else if (step) begin
            corner_q <= corner_n;
            row_q    <= row_n;
            col_q    <= col_n;
        end
    end
endmodule

// File: rtl/raster_map.sv
module raster_map #(
    parameter int ROWS_LOG2 = 12,
    parameter int COLS_LOG2 = 12
) (
    input  ccd_reorder_pkg::corner_e           corner,
    input  logic [ROWS_LOG2-2:0]               qrow,
    input  logic [COLS_LOG2-2:0]               qcol,
    output logic [ROWS_LOG2+COLS_LOG2-1:0]     addr
);
    import ccd_reorder_pkg::*;

    localparam int QROW_W = ROWS_LOG2 - 1;
    localparam int QCOL_W = COLS_LOG2 - 1;

    logic                 up, left;
    logic [QROW_W-1:0]    row_lo;
    logic [QCOL_W-1:0]    col_lo;

    assign up   = scans_up(corner);
    assign left = scans_left(corner);

    // (N-1-x) for x < N/2 equals {1, ~x}: mirror by inverting each bit.
    for (genvar i = 0; i < QROW_W; i++) begin : g_row
        assign row_lo[i] = qrow[i] ^ up;
    end
    for (genvar j = 0; j < QCOL_W; j++) begin : g_col
        assign col_lo[j] = qcol[j] ^ left;
    end

    assign addr = {up, row_lo, left, col_lo};
endmodule

// File: rtl/frame_track.sv
module frame_track (
    input  logic clk,
    input  logic rst,
    input  logic beat,
    input  logic sop,
    input  logic last_pix,
    output logic take,
    output logic len_err
);
    logic active_q;

    assign take = beat && (sop || active_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            len_err  <= 1'b0;
        end else begin
            if (take) begin
                active_q <= !last_pix;
            end
            if (beat && (sop == active_q)) begin
                len_err <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ccd_corner_reorder.sv
module ccd_corner_reorder #(
    parameter int ROWS_LOG2 = 12,
    parameter int COLS_LOG2 = 12,
    parameter int PIX_W     = ccd_reorder_pkg::PIXEL_BITS
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              in_valid,
    output logic                              in_ready,
    input  logic                              in_sop,
    input  logic [PIX_W-1:0]                  in_data,
    output logic                              wr_en,
    output logic [ROWS_LOG2+COLS_LOG2-1:0]    wr_addr,
    output logic [PIX_W-1:0]                  wr_data,
    output logic                              frame_done,
    output logic                              len_err
);
    import ccd_reorder_pkg::*;

    localparam int AW     = ROWS_LOG2 + COLS_LOG2;
    localparam int QROW_W = ROWS_LOG2 - 1;
    localparam int QCOL_W = COLS_LOG2 - 1;

    logic               beat, take, last_pix, restart;
    corner_e            corner;
    logic [QROW_W-1:0]  qrow;
    logic [QCOL_W-1:0]  qcol;
    logic [AW-1:0]      addr_c;

    assign in_ready = 1'b1;
    assign beat     = in_valid;
    assign restart  = beat && in_sop;

    quad_seq #(.QROW_W(QROW_W), .QCOL_W(QCOL_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .step     (take),
        .restart  (restart),
        .corner   (corner),
        .qrow     (qrow),
        .qcol     (qcol),
        .last_pix (last_pix)
    );

    raster_map #(.ROWS_LOG2(ROWS_LOG2), .COLS_LOG2(COLS_LOG2)) u_map (
        .corner (corner),
        .qrow   (qrow),
        .qcol   (qcol),
        .addr   (addr_c)
    );

    frame_track u_trk (
        .clk      (clk),
        .rst      (rst),
        .beat     (beat),
        .sop      (in_sop),
        .last_pix (last_pix),
        .take     (take),
        .len_err  (len_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en      <= 1'b0;
            frame_done <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
        end else begin
            wr_en      <= take;
            frame_done <= take && last_pix;
            if (take) begin
                wr_addr <= addr_c;
                wr_data <= in_data;
            end
        end
    end
endmodule

// File: rtl/ccd_corner_reorder_chk.sv
module ccd_corner_reorder_chk #(
    parameter int PIX_W  = 16,
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_sop,
    input logic [PIX_W-1:0]  in_data,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [PIX_W-1:0]  wr_data,
    input logic              frame_done,
    input logic              len_err
);
    p_sop_writes_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sop) |=> wr_en);

    p_sop_data_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sop) |=> (wr_data == $past(in_data)));

    p_sop_addr_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sop) |=> (wr_addr == '0));

    p_done_on_write_r6: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> wr_en);

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    p_idle_no_write_r7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !wr_en);

    p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        len_err |=> len_err);
endmodule

bind ccd_corner_reorder ccd_corner_reorder_chk #(
    .PIX_W  (PIX_W),
    .ADDR_W (ROWS_LOG2 + COLS_LOG2)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_sop     (in_sop),
    .in_data    (in_data),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .frame_done (frame_done),
    .len_err    (len_err)
);

// File: tb/ccd_corner_reorder_bench.sv
`timescale 1ns/1ps
module ccd_corner_reorder_bench;
    localparam int RL = 3;
    localparam int CL = 3;
    localparam int NR = 1 << RL;
    localparam int NC = 1 << CL;
    localparam int NPIX = NR * NC;
    localparam int AW = RL + CL;

    // {pixel index, expected address} spot vectors for an 8x8 frame
    localparam int NVEC = 12;
    localparam int VEC [NVEC][2] = '{
        '{0, 0},  '{1, 7},  '{2, 56}, '{3, 63},
        '{4, 1},  '{5, 6},  '{15, 60}, '{16, 8},
        '{17, 15}, '{18, 48}, '{62, 35}, '{63, 36}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0, in_sop = 1'b0;
    logic [15:0] in_data = '0;
    logic in_ready, wr_en, frame_done, len_err;
    logic [AW-1:0] wr_addr;
    logic [15:0] wr_data;

    int n_chk = 0, n_bad = 0;
    int wcount = 0, done_cnt = 0, done_at = -1;
    int cap_addr [0:127];
    int cap_data [0:127];
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ccd_corner_reorder #(.ROWS_LOG2(RL), .COLS_LOG2(CL), .PIX_W(16)) u_ccd_corner_reorder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_sop(in_sop), .in_data(in_data), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .frame_done(frame_done), .len_err(len_err)
    );

    always @(negedge clk) begin
        if (wr_en) begin
            if (wcount < 128) begin
                cap_addr[wcount] = int'(wr_addr);
                cap_data[wcount] = int'(wr_data);
            end
            if (frame_done) begin
                done_cnt++;
                done_at = wcount;
            end
            wcount++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_addr(input int k);
        int lane = k % 4;
        int g = k / 4;
        int c = g % (NC / 2);
        int r = g / (NC / 2);
        int row = (lane >= 2) ? (NR - 1 - r) : r;
        int col = (lane % 2 == 1) ? (NC - 1 - c) : c;
        return row * NC + col;
    endfunction

    task automatic clear_cap();
        wcount = 0; done_cnt = 0; done_at = -1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; in_sop = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; in_valid = 1'b0; in_sop = 1'b0;
        idle(2);
        @(negedge clk); rst = 1'b0;
    endtask

    // gaps: idle cycles between beats carry sop=1 and junk data with valid=0
    task automatic send(input int n, input bit mark, input bit gaps);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sop = mark && (i == 0);
            in_data = 16'hC000 + 16'(i);
            if (gaps) begin
                @(negedge clk);
                in_valid = 1'b0; in_sop = 1'b1; in_data = 16'hFFFF;
            end
        end
        @(negedge clk); in_valid = 1'b0; in_sop = 1'b0;
    endtask

    task automatic check_frame(input int base, input string req);
        bit seen [0:NPIX-1];
        int dup = 0;
        for (int i = 0; i < NPIX; i++) seen[i] = 1'b0;
        for (int i = 0; i < NPIX; i++) begin
            check(cap_addr[base+i] == exp_addr(i), req, cap_addr[base+i], exp_addr(i));
            check(cap_data[base+i] == 32'hC000 + i, "R4 data", cap_data[base+i], 32'hC000 + i);
            if (seen[cap_addr[base+i]]) dup++;
            seen[cap_addr[base+i]] = 1'b1;
        end
        check(dup == 0, "R3 each address once", dup, 0);
    endtask

    initial begin
        do_reset();
        @(negedge clk);
        // R1 reset state
        check(wr_en == 0, "R1 wr_en", int'(wr_en), 0);
        check(frame_done == 0, "R1 frame_done", int'(frame_done), 0);
        check(len_err == 0, "R1 len_err", int'(len_err), 0);
        check(in_ready == 1, "R1 in_ready", int'(in_ready), 1);

        // Full frame, back to back
        clear_cap();
        send(NPIX, 1'b1, 1'b0);
        idle(3);
        check(wcount == NPIX, "R4 write count", wcount, NPIX);
        for (int v = 0; v < NVEC; v++)
            check(cap_addr[VEC[v][0]] == VEC[v][1], "R2 corner vector",
                  cap_addr[VEC[v][0]], VEC[v][1]);
        check_frame(0, "R3 address");
        check(done_cnt == 1, "R6 done count", done_cnt, 1);
        check(done_at == NPIX - 1, "R6 done position", done_at, NPIX - 1);
        check(len_err == 0, "R8 no error on exact frame", int'(len_err), 0);

        // Run-long pixel after a complete frame
        clear_cap();
        send(1, 1'b0, 1'b0);
        idle(2);
        check(wcount == 0, "R8 stray not written", wcount, 0);
        check(len_err == 1, "R8 stray sets len_err", int'(len_err), 1);

        // sop with valid low, then idle: no write, error held
        @(negedge clk); in_valid = 1'b0; in_sop = 1'b1; in_data = 16'h1234;
        idle(4);
        check(wcount == 0, "R7 invalid sop ignored", wcount, 0);
        check(len_err == 1, "R10 len_err sticky", int'(len_err), 1);

        do_reset();
        @(negedge clk);
        check(len_err == 0, "R10 cleared by reset", int'(len_err), 0);

        // Data before any marker
        clear_cap();
        send(3, 1'b0, 1'b0);
        idle(2);
        check(wcount == 0, "R8 pre-marker not written", wcount, 0);
        check(len_err == 1, "R8 pre-marker error", int'(len_err), 1);

        // Short packet followed by a new frame
        do_reset();
        clear_cap();
        send(10, 1'b1, 1'b0);
        idle(1);
        check(len_err == 0, "R9 no error before cut", int'(len_err), 0);
        send(NPIX, 1'b1, 1'b0);
        idle(3);
        check(len_err == 1, "R9 short packet error", int'(len_err), 1);
        check(wcount == 10 + NPIX, "R4 write count", wcount, 10 + NPIX);
        check(cap_addr[10] == 0, "R5 restart at zero", cap_addr[10], 0);
        check_frame(10, "R5 address after restart");
        check(done_at == 10 + NPIX - 1, "R6 done after restart", done_at, 10 + NPIX - 1);
        check(done_cnt == 1, "R6 single done", done_cnt, 1);

        // Gapped frame with sop toggling on idle cycles
        do_reset();
        clear_cap();
        send(NPIX, 1'b1, 1'b1);
        idle(3);
        check(wcount == NPIX, "R7 gapped write count", wcount, NPIX);
        check_frame(0, "R7 gapped address");
        check(done_cnt == 1, "R7 gapped done", done_cnt, 1);
        check(len_err == 0, "R7 no error", int'(len_err), 0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule